// File: doc/BRIEF.md
# Serial RTC and SRAM Slave

This block is the slave end of a one-bit serial expansion link. Behind it sit a free-running 32-bit seconds counter, a small bank of SRAM words that are treated as battery-backed, a latched copy of the counter, two timer registers, a read/write control word, a read-only status word and four read-only test locations. A one-cycle `tick` pulse stands in for the one-second oscillator. Power-fail and low-battery sensing arrive as plain pins.

A transfer opens while `sel` is high. Each transfer is a 32-bit command word followed by a 32-bit data phase, both sent most significant bit first. The command word carries the write flag in bit 31 and the 24-bit register address shifted left by eight. Because bit 31 coincides with address bit 23, the address is taken from bits 30:8 with bit 23 treated as zero. A read returns the addressed register during the data phase, and a write loads it when the last data bit arrives. Permissions are enforced per address: some registers are read-only, and unmapped addresses read as zero.

The serial input is a valid-only stream. The slave has no ready signal and no back-pressure. It accepts one bit on every cycle in which `sel` and `sdi_valid` are both high. The master paces the transfer by holding `sdi_valid` low for any number of cycles. Read data on `sdo` is stable between accepted bits and shows the next data bit before the cycle that accepts it.

Top module: `rtc_sram_slave`

## Requirements
- R1: A transfer is 32 command bits then 32 data bits, each accepted MSB first on a clock edge where `sel` and `sdi_valid` are high. Command bit 31 set means write. Command bits 30:8 give address bits 22:0, address bit 23 is zero, and command bits 7:0 are ignored. During a read's data phase, `sdo` shows data bit 31-k before the k-th data bit is accepted.
- R2: Address 0x200000 is the seconds counter. It is readable and writable and adds one on every clock edge where `tick` is high, wrapping from 0xFFFFFFFF to 0. A write that commits on the same edge as a tick takes priority over the tick.
- R3: Addresses 0x200001 to 0x200010 are 16 independent read/write SRAM words. This range includes the time-bias word at 0x200004.
- R4: The on-timer (0x210000), the off-timer (0x210001) and control word 1 (0x21000D) are 32-bit read/write registers.
- R5: A write to 0x204000 copies the counter value present at the committing edge into the snapshot, and the written data is ignored. Reads of 0x204000 return the last copy.
- R6: The test locations 0x210004 to 0x210007 read as zero. Writes to them and to control word 0 (0x21000C) are discarded.
- R7: Control word 0 has the unstable-power flag in bit 11 and the live `low_batt` level in bit 9; all other bits are zero. The flag is set by any cycle with `pwr_fail` high, stays set, and clears when a read of control word 0 completes its command phase, unless `pwr_fail` is high on that edge.
- R8: Reads of any other address return zero, and writes to any other address change no register.
- R9: Low `sel` aborts a transfer at any point without committing it, and the next selected bit starts a new command word. After a complete data phase, further bits are ignored until `sel` goes low.
- R10: After reset every register, the snapshot and the flag are zero, and `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, high for the duration of a transfer |
| sdi_valid | input | 1 | Serial input bit is valid this cycle |
| sdi | input | 1 | Serial input bit |
| sdo | output | 1 | Serial output bit |
| tick | input | 1 | One-second pulse, counts once per high cycle |
| pwr_fail | input | 1 | Power instability indication |
| low_batt | input | 1 | Low backup battery indication |

## Verification
A wrong framing count or a lost abort shows at once as a shifted or foreign read value in the very next transfer. A lost or doubled tick, a stale snapshot or a flag that fails to stick or clear shows on the first read of the counter, snapshot or control word 0 after the event. A write that leaks into a read-only or unmapped location, or aliases onto another word, stays hidden until that word is read back. For that reason the stimulus mixes random writes and reads over every region and keeps a complete model of all locations.

// File: rtl/rtc_sram_pkg.sv
package rtc_sram_pkg;

  localparam int ADDR_W = 24;

  localparam logic [ADDR_W-1:0] A_COUNTER = 24'h200000;
  localparam logic [ADDR_W-1:0] A_SRAM0   = 24'h200001;
  localparam logic [ADDR_W-1:0] A_SNAP    = 24'h204000;
  localparam logic [ADDR_W-1:0] A_ON_TMR  = 24'h210000;
  localparam logic [ADDR_W-1:0] A_OFF_TMR = 24'h210001;
  localparam logic [ADDR_W-1:0] A_TEST0   = 24'h210004;
  localparam logic [ADDR_W-1:0] A_CTRL0   = 24'h21000C;
  localparam logic [ADDR_W-1:0] A_CTRL1   = 24'h21000D;
  localparam int TEST_WORDS   = 4;
  localparam int UNSTABLE_BIT = 11;
  localparam int LOWBAT_BIT   = 9;

  typedef enum logic [3:0] {
    RG_NONE, RG_COUNT, RG_SRAM, RG_SNAP, RG_ON, RG_OFF, RG_TEST, RG_CTRL0, RG_CTRL1
  } region_t;

  typedef enum logic [1:0] {FS_CMD, FS_DATA, FS_DONE} fstate_t;

  function automatic region_t decode_addr(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] sram_words);
    region_t r;
    r = RG_NONE;
    if (a == A_COUNTER)                                  r = RG_COUNT;
    else if (a >= A_SRAM0 && a < A_SRAM0 + sram_words)   r = RG_SRAM;
    else if (a == A_SNAP)                                r = RG_SNAP;
    else if (a == A_ON_TMR)                              r = RG_ON;
    else if (a == A_OFF_TMR)                             r = RG_OFF;
    else if (a >= A_TEST0 && a < A_TEST0 + ADDR_W'(TEST_WORDS)) r = RG_TEST;
    else if (a == A_CTRL0)                               r = RG_CTRL0;
    else if (a == A_CTRL1)                               r = RG_CTRL1;
    return r;
  endfunction

endpackage

// File: rtl/rtc_serial_frame.sv
module rtc_serial_frame
  import rtc_sram_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sdi_valid,
  input  logic              sdi,
  output logic              sdo,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int AFLD_W = ADDR_W - 1;

  fstate_t           st_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] out_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;

  logic              step, last;
  logic [WORD_W-1:0] word_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              is_wr_nxt;

  always_comb begin
    step      = sel && sdi_valid;
    last      = (bitcnt_q == CNT_W'(WORD_W - 1));
    word_nxt  = {sh_q[WORD_W-2:0], sdi};
    is_wr_nxt = word_nxt[WORD_W-1];
    addr_nxt  = {1'b0, word_nxt[WORD_W-2 -: AFLD_W]};
    addr      = (st_q == FS_CMD) ? addr_nxt : addr_q;
    rd_stb    = step && (st_q == FS_CMD) && last && !is_wr_nxt;
    wr_stb    = step && (st_q == FS_DATA) && last && wr_q;
    wr_data   = word_nxt;
    sdo       = (st_q == FS_DATA) ? out_q[WORD_W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_CMD;
      bitcnt_q <= '0;
      sh_q     <= '0;
      out_q    <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
    end else if (!sel) begin
      st_q     <= FS_CMD;
      bitcnt_q <= '0;
      sh_q     <= '0;
      out_q    <= '0;
    end else if (sdi_valid) begin
      unique case (st_q)
        FS_CMD: begin
          sh_q     <= word_nxt;
          bitcnt_q <= bitcnt_q + CNT_W'(1);
          if (last) begin
            st_q   <= FS_DATA;
            wr_q   <= is_wr_nxt;
            addr_q <= addr_nxt;
            out_q  <= is_wr_nxt ? '0 : rd_data;
          end
        end
        FS_DATA: begin
          sh_q     <= word_nxt;
          out_q    <= {out_q[WORD_W-2:0], 1'b0};
          bitcnt_q <= bitcnt_q + CNT_W'(1);
          if (last) st_q <= FS_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_ABORT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (st_q == FS_CMD) && (bitcnt_q == '0)); // R9
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_DONE) && sel |=> (st_q == FS_DONE)); // R9
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_DATA) |-> !sdo); // R10

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_sram_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_wr,
  input  logic              snap_wr,
  input  logic              ctrl0_rd,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pwr_fail,
  input  logic              low_batt,
  output logic [WORD_W-1:0] count,
  output logic [WORD_W-1:0] snap,
  output logic [WORD_W-1:0] ctrl0
);
  logic [WORD_W-1:0] cnt_q, snap_q;
  logic              unst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      unst_q <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= wr_data;
      else if (tick) cnt_q <= cnt_q + WORD_W'(1);
      if (snap_wr)   snap_q <= cnt_q;
      unst_q <= pwr_fail | (unst_q & ~ctrl0_rd);
    end
  end

  always_comb begin
    ctrl0               = '0;
    ctrl0[UNSTABLE_BIT] = unst_q;
    ctrl0[LOWBAT_BIT]   = low_batt;
    count               = cnt_q;
    snap                = snap_q;
  end

  AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr |=> cnt_q == $past(cnt_q) + WORD_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(cnt_q)); // R2
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(snap_q)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> unst_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unst_q && !ctrl0_rd |=> unst_q); // R7

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_sram_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SRAM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] count,
  input  logic [WORD_W-1:0] snap,
  input  logic [WORD_W-1:0] ctrl0,
  output logic [WORD_W-1:0] rd_data,
  output logic              cnt_wr,
  output logic              snap_wr,
  output logic              ctrl0_rd
);
  localparam int IDX_W = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1;

  region_t           rg;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] sram_rd [SRAM_WORDS];
  logic [WORD_W-1:0] on_q, off_q, ctrl1_q;

  always_comb begin
    rg       = decode_addr(addr, ADDR_W'(SRAM_WORDS));
    idx      = IDX_W'(addr - A_SRAM0);
    cnt_wr   = wr_stb && (rg == RG_COUNT);
    snap_wr  = wr_stb && (rg == RG_SNAP);
    ctrl0_rd = rd_stb && (rg == RG_CTRL0);
  end

  for (genvar g = 0; g < SRAM_WORDS; g++) begin : g_sram
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (wr_stb && (rg == RG_SRAM) && (idx == IDX_W'(g))) word_q <= wr_data;
    end
    assign sram_rd[g] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= '0;
      off_q   <= '0;
      ctrl1_q <= '0;
    end else if (wr_stb) begin
      if (rg == RG_ON)    on_q    <= wr_data;
      if (rg == RG_OFF)   off_q   <= wr_data;
      if (rg == RG_CTRL1) ctrl1_q <= wr_data;
    end
  end

  always_comb begin
    unique case (rg)
      RG_COUNT: rd_data = count;
      RG_SRAM:  rd_data = sram_rd[idx];
      RG_SNAP:  rd_data = snap;
      RG_ON:    rd_data = on_q;
      RG_OFF:   rd_data = off_q;
      RG_CTRL0: rd_data = ctrl0;
      RG_CTRL1: rd_data = ctrl1_q;
      default:  rd_data = '0;
    endcase
  end

  AST_CTRL1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && addr == A_CTRL1) |=> $stable(ctrl1_q)); // R4
  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && addr == A_ON_TMR) |=> $stable(on_q)); // R4
  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rg == RG_NONE || rg == RG_TEST) |-> rd_data == '0); // R8

endmodule

// File: rtl/rtc_sram_slave.sv
module rtc_sram_slave
  import rtc_sram_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SRAM_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sdi_valid,
  input  logic sdi,
  output logic sdo,
  input  logic tick,
  input  logic pwr_fail,
  input  logic low_batt
);
  logic [WORD_W-1:0] rd_data, wr_data, count, snap, ctrl0;
  logic [ADDR_W-1:0] addr;
  logic              rd_stb, wr_stb, cnt_wr, snap_wr, ctrl0_rd;

  rtc_serial_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sdi_valid(sdi_valid), .sdi(sdi),
    .sdo(sdo), .rd_data(rd_data), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wr_data(wr_data)
  );

  rtc_time_core #(.WORD_W(WORD_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .snap_wr(snap_wr),
    .ctrl0_rd(ctrl0_rd), .wr_data(wr_data), .pwr_fail(pwr_fail),
    .low_batt(low_batt), .count(count), .snap(snap), .ctrl0(ctrl0)
  );

  rtc_reg_bank #(.WORD_W(WORD_W), .SRAM_WORDS(SRAM_WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .count(count), .snap(snap), .ctrl0(ctrl0),
    .rd_data(rd_data), .cnt_wr(cnt_wr), .snap_wr(snap_wr), .ctrl0_rd(ctrl0_rd)
  );

endmodule

// File: tb/rtc_sram_slave_tb.sv
module rtc_sram_slave_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, sdi_valid = 1'b0, sdi = 1'b0;
  logic tick = 1'b0, pwr_fail = 1'b0, low_batt = 1'b0;
  logic sdo;

  int checks = 0, errors = 0;
  logic [31:0] m_cnt, m_snap, m_on, m_off, m_ctrl1;
  logic [31:0] m_sram [16];
  logic        m_unst;

  always #(CLK_P/2) clk = ~clk;

  rtc_sram_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sdi_valid(sdi_valid), .sdi(sdi),
    .sdo(sdo), .tick(tick), .pwr_fail(pwr_fail), .low_batt(low_batt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [23:0] a);
    if (a == 24'h200000) return m_cnt;
    if (a >= 24'h200001 && a <= 24'h200010) return m_sram[a - 24'h200001];
    if (a == 24'h204000) return m_snap;
    if (a == 24'h210000) return m_on;
    if (a == 24'h210001) return m_off;
    if (a == 24'h21000C) return (32'(m_unst) << 11) | (32'(low_batt) << 9);
    if (a == 24'h21000D) return m_ctrl1;
    return 32'h0;
  endfunction

  function automatic void model_wr(input logic [23:0] a, input logic [31:0] d);
    if (a == 24'h200000) m_cnt = d;
    else if (a >= 24'h200001 && a <= 24'h200010) m_sram[a - 24'h200001] = d;
    else if (a == 24'h204000) m_snap = m_cnt;
    else if (a == 24'h210000) m_on = d;
    else if (a == 24'h210001) m_off = d;
    else if (a == 24'h21000D) m_ctrl1 = d;
  endfunction

  // shift the top n bits of w, MSB first, with random idle gaps; sample sdo per bit
  task automatic shift_bits(input logic [31:0] w, input int n, input bit tick_last,
                            output logic [31:0] got);
    got = '0;
    for (int i = 31; i > 31 - n; i--) begin
      if ($urandom % 4 == 0) begin
        @(negedge clk); sel = 1'b1; sdi_valid = 1'b0;
      end
      @(negedge clk);
      got[i] = sdo;
      sel = 1'b1; sdi_valid = 1'b1; sdi = w[i];
      tick = tick_last && (i == 0);
    end
    @(negedge clk); sdi_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic end_xfer();
    sel = 1'b0; sdi_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic xfer(input bit wr, input logic [23:0] a, input logic [7:0] lowb,
                      input logic [31:0] wd, input bit tick_last, output logic [31:0] rd);
    logic [31:0] cmd, dummy;
    cmd = (32'(a) << 8) | {24'h0, lowb};
    cmd[31] = wr;
    shift_bits(cmd, 32, 1'b0, dummy);
    shift_bits(wd, 32, tick_last, rd);
    end_xfer();
  endtask

  task automatic do_rd(input logic [23:0] a, input string req);
    logic [31:0] r;
    logic [31:0] e;
    e = model_rd(a);
    xfer(1'b0, a, 8'(a), 32'h0, 1'b0, r);
    if (a == 24'h21000C) m_unst = 1'b0;
    chk(req, r, e);
  endtask

  task automatic do_wr(input logic [23:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, 8'hA5, d, 1'b0, r);
    model_wr(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; m_cnt = m_cnt + 1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [23:0] pick_addr();
    case ($urandom % 10)
      0: return 24'h200000;
      1, 2: return 24'h200001 + 24'($urandom % 16);
      3: return 24'h204000;
      4: return 24'h210000 + 24'($urandom % 2);
      5: return 24'h210004 + 24'($urandom % 4);
      6: return 24'h21000C;
      7: return 24'h21000D;
      8: return 24'h200011;
      default: begin
        case ($urandom % 4)
          0: return 24'h210002;
          1: return 24'h21000E;
          2: return 24'h204001;
          default: return 24'h3FFFFF;
        endcase
      end
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20251));
    m_cnt = 0; m_snap = 0; m_on = 0; m_off = 0; m_ctrl1 = 0; m_unst = 0;
    for (int i = 0; i < 16; i++) m_sram[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 sdo", 32'(sdo), 32'h0);
    do_rd(24'h200000, "R10 counter");
    do_rd(24'h21000D, "R10 ctrl1");
    do_rd(24'h200004, "R10 bias word");
    do_rd(24'h204000, "R10 snapshot");

    // R3 SRAM fill and readback, including bias word
    for (int i = 0; i < 16; i++) do_wr(24'h200001 + 24'(i), 32'hC0DE0000 + 32'(i * 7));
    for (int i = 0; i < 16; i++) do_rd(24'h200001 + 24'(i), "R3 sram");

    // R2 wrap and write priority over tick
    do_wr(24'h200000, 32'hFFFFFFFE);
    ticks(3);
    do_rd(24'h200000, "R2 wrap");
    xfer(1'b1, 24'h200000, 8'h00, 32'h12345678, 1'b1, r);
    m_cnt = 32'h12345678;
    do_rd(24'h200000, "R2 write beats tick");

    // R5 snapshot
    do_wr(24'h204000, 32'hDEADBEEF);
    ticks(5);
    do_rd(24'h204000, "R5 snapshot latched");
    do_rd(24'h200000, "R5 counter moved");

    // R4 timers and ctrl1
    do_wr(24'h210000, 32'h0000_1111);
    do_wr(24'h210001, 32'h2222_0000);
    do_wr(24'h21000D, 32'h8000_0001);
    do_rd(24'h210000, "R4 on timer");
    do_rd(24'h210001, "R4 off timer");
    do_rd(24'h21000D, "R4 ctrl1");

    // R6 read-only locations
    for (int i = 0; i < 4; i++) begin
      do_wr(24'h210004 + 24'(i), 32'hFFFFFFFF);
      do_rd(24'h210004 + 24'(i), "R6 test reads zero");
    end
    do_wr(24'h21000C, 32'hFFFFFFFF);
    do_rd(24'h21000C, "R6 ctrl0 not writable");

    // R7 sticky flag and live low battery
    @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0; m_unst = 1'b1;
    low_batt = 1'b1;
    repeat (4) @(negedge clk);
    do_rd(24'h21000C, "R7 flag set with low batt");
    do_rd(24'h21000C, "R7 flag cleared by read");
    low_batt = 1'b0;
    do_rd(24'h21000C, "R7 low batt follows pin");

    // R8 unmapped writes do not alias
    do_wr(24'h200011, 32'h5555AAAA);
    do_wr(24'h21000E, 32'h5555AAAA);
    do_wr(24'h3FFFFF, 32'h5555AAAA);
    do_rd(24'h200011, "R8 unmapped reads zero");
    do_rd(24'h200010, "R8 last sram unchanged");
    do_rd(24'h21000D, "R8 ctrl1 unchanged");

    // R9 abort mid data phase, mid command, and bits after completion
    begin
      logic [31:0] cmd;
      cmd = 32'h8000_0000 | (32'h21000D << 8);
      shift_bits(cmd, 32, 1'b0, r);
      shift_bits(32'h0BAD0BAD, 17, 1'b0, r);
      end_xfer();
      do_rd(24'h21000D, "R9 aborted write");
      shift_bits(cmd, 11, 1'b0, r);
      end_xfer();
      do_rd(24'h210000, "R9 after command abort");
      shift_bits(32'h8000_0000 | (32'h210001 << 8), 32, 1'b0, r);
      shift_bits(32'h7777_7777, 32, 1'b0, r);
      m_off = 32'h7777_7777;
      shift_bits(32'h8000_0000 | (32'h210000 << 8), 32, 1'b0, r);
      shift_bits(32'h9999_9999, 32, 1'b0, r);
      end_xfer();
      do_rd(24'h210000, "R9 bits after done ignored");
      do_rd(24'h210001, "R9 full write kept");
    end

    // R1 random mix (random low command byte inside do_rd via address bits)
    for (int n = 0; n < 300; n++) begin
      logic [23:0] a;
      a = pick_addr();
      if ($urandom % 3 == 0) ticks($urandom % 3);
      if ($urandom % 16 == 0) begin
        @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0; m_unst = 1'b1;
      end
      if ($urandom % 8 == 0) low_batt = ~low_batt;
      if ($urandom % 2 == 0) begin
        logic [31:0] d;
        logic [7:0] lb;
        d = $urandom; lb = 8'($urandom);
        xfer(1'b1, a, lb, d, 1'b0, r);
        model_wr(a, d);
      end else begin
        logic [31:0] e;
        logic [7:0] lb;
        e = model_rd(a); lb = 8'($urandom);
        xfer(1'b0, a, lb, 32'($urandom), 1'b0, r);
        if (a == 24'h21000C) m_unst = 1'b0;
        chk("R1 random access", r, e);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule